// File: doc/BRIEF.md
# Priority Interrupt Controller

This block collects level-sensitive interrupt requests from a parameterised number of peripheral sources, up to 128, grouped in banks of 32. Software enables sources individually and steers each one to either the normal interrupt line or the fast interrupt line. It then reads back masked views of what is pending, so a handler can find its work. The controller drives a normal interrupt output, a fast interrupt output and an idle-wakeup output, all registered.

A table of priority slots, one per source, lets software place any source at any priority. Slot 0 ranks highest. Each slot holds a valid flag and a source number. A dedicated status word reports the source of the best-ranked valid slot whose source is pending, enabled and routed to the normal line, together with a flag saying whether such a source exists. The interrupt handler reads this word to dispatch without scanning.

Access is through a plain 32-bit register port with a write strobe and an address. Read data is registered and appears one cycle after the address. Each source is sampled every cycle with no edge capture: a request is pending exactly while its input is high.

Top module: `prio_intc`

## Requirements
- R1: While reset is asserted and right after it, `irq_o`, `fiq_o` and `wake_o` are 0. The enable, route, control and slot registers all read 0, so the winner word at 0x018 reads 0.
- R2: The raw word at bank offset +0x10 returns the current source levels of that bank, whatever the enable and route settings. Writes to it change nothing.
- R3: The normal-pending word at bank offset +0x00 reads raw AND enable AND NOT route. The fast-pending word at bank offset +0x0C reads raw AND enable AND route. Writes to either change nothing.
- R4: The enable register is at bank offset +0x04, with 1 enabling the source. The route register is at bank offset +0x08, with 0 selecting the normal line and 1 the fast line. Both read back what was written for sources that exist. Bank bases are 0x000, 0x09C, 0x130 and 0x244 for banks 0 to 3.
- R5: `irq_o` is the OR of all normal-pending bits and `fiq_o` the OR of all fast-pending bits. Each follows a source change with one clock of latency.
- R6: The winner word at 0x018 has bit 31 set when some valid slot names a source that is pending, enabled and routed to the normal line. Bits 30:16 then carry that source number, taken from the lowest-indexed such slot; all other bits are 0. The word is 0 when there is no such slot.
- R7: Slot i sits at 0x01C+4i for i<32, at 0x0B0+4(i-32) for 32≤i<64 and at 0x144+4(i-64) for 64≤i<128. Bit 31 is the valid flag and bits 6:0 the source number; other bits read 0. A slot whose flag is clear, or whose number names no source, never wins.
- R8: Bit 0 of the control word at 0x014 selects wakeup mode. With 0, any raw-pending source drives `wake_o`. With 1, only enabled pending sources do, regardless of route. `wake_o` is registered.
- R9: Reads of addresses that map to no register return 0, and writes to them change no register.
- R10: `rdata_o` shows the register addressed by `addr_i` one clock later and holds its old value until that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Level-sensitive source requests |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 12 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |
| wake_o | output | 1 | Idle-wakeup request |

## Verification
The properties assume the source inputs are synchronous to the clock and stay low while reset is held. Under that assumption, a quiet cycle on the sources means quiet outputs one clock later, and a valid winner always coincides with a raised normal line. Addresses are taken to be word aligned, with the upper half of the space unused. The bench drives every input just after the falling edge, holds the sources at zero through reset, and issues only aligned addresses. The only high addresses it uses are deliberate probes of unmapped space.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;

    localparam int BANK_W  = 32;
    localparam int MAX_SRC = 128;
    localparam int NUM_W   = 7;
    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;

    localparam logic [ADDR_W-1:0] CTRL_ADDR = 12'h014;
    localparam logic [ADDR_W-1:0] WIN_ADDR  = 12'h018;

    typedef enum logic [2:0] {
        BR_IRQ_PEND,
        BR_ENABLE,
        BR_ROUTE,
        BR_FIQ_PEND,
        BR_RAW,
        BR_NONE
    } bank_reg_e;

    function automatic logic [ADDR_W-1:0] bank_base(input int b);
        case (b)
            0:       return 12'h000;
            1:       return 12'h09C;
            2:       return 12'h130;
            default: return 12'h244;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] slot_addr(input int i);
        logic [ADDR_W-1:0] idx;
        idx = ADDR_W'(i);
        if (i < 32)      return 12'h01C + (idx << 2);
        else if (i < 64) return 12'h0B0 + ((idx - 12'd32) << 2);
        else             return 12'h144 + ((idx - 12'd64) << 2);
    endfunction

    function automatic bank_reg_e bank_decode(input logic [ADDR_W-1:0] a,
                                              input logic [ADDR_W-1:0] base);
        if (a == base)                return BR_IRQ_PEND;
        else if (a == base + 12'h004) return BR_ENABLE;
        else if (a == base + 12'h008) return BR_ROUTE;
        else if (a == base + 12'h00C) return BR_FIQ_PEND;
        else if (a == base + 12'h010) return BR_RAW;
        else                          return BR_NONE;
    endfunction

endpackage

// File: rtl/prio_intc_bank.sv
module prio_intc_bank
    import prio_intc_pkg::*;
#(
    parameter int LIVE = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  bank_reg_e         sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [BANK_W-1:0] src_i,
    output logic [BANK_W-1:0] enable_o,
    output logic [BANK_W-1:0] route_o,
    output logic [BANK_W-1:0] irq_vec_o,
    output logic [BANK_W-1:0] fiq_vec_o,
    output logic [DATA_W-1:0] rd_o
);

    localparam logic [BANK_W:0]   LIVE_TOP = (BANK_W+1)'(1) << LIVE;
    localparam logic [BANK_W-1:0] LIVE_M   = LIVE_TOP[BANK_W-1:0] - BANK_W'(1);

    typedef struct packed {
        logic [BANK_W-1:0] enable;
        logic [BANK_W-1:0] route;
    } bank_state_t;

    bank_state_t       st_d, st_q;
    logic [BANK_W-1:0] raw;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            case (sel_i)
                BR_ENABLE: st_d.enable = wdata_i & LIVE_M;
                BR_ROUTE:  st_d.route  = wdata_i & LIVE_M;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign raw       = src_i & LIVE_M;
    assign enable_o  = st_q.enable;
    assign route_o   = st_q.route;
    assign irq_vec_o = raw & st_q.enable & ~st_q.route;
    assign fiq_vec_o = raw & st_q.enable & st_q.route;

    always_comb begin
        case (sel_i)
            BR_IRQ_PEND: rd_o = irq_vec_o;
            BR_ENABLE:   rd_o = st_q.enable;
            BR_ROUTE:    rd_o = st_q.route;
            BR_FIQ_PEND: rd_o = fiq_vec_o;
            BR_RAW:      rd_o = raw;
            default:     rd_o = '0;
        endcase
    end

endmodule

// File: rtl/prio_intc_sel.sv
module prio_intc_sel
    import prio_intc_pkg::*;
#(
    parameter int NUM_SLOT = 64
) (
    input  logic [NUM_SLOT-1:0]            slot_vld_i,
    input  logic [NUM_SLOT-1:0][NUM_W-1:0] slot_num_i,
    input  logic [MAX_SRC-1:0]             elig_i,
    output logic                           found_o,
    output logic [NUM_W-1:0]               win_o
);

    // Scan from the lowest rank upward so the last hit is slot 0 side.
    always_comb begin
        found_o = 1'b0;
        win_o   = '0;
        for (int i = NUM_SLOT - 1; i >= 0; i--) begin
            if (slot_vld_i[i] && elig_i[slot_num_i[i]]) begin
                found_o = 1'b1;
                win_o   = slot_num_i[i];
            end
        end
    end

endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic               irq_o,
    output logic               fiq_o,
    output logic               wake_o
);

    localparam int NUM_BANK = (NUM_SRC + BANK_W - 1) / BANK_W;
    localparam int PAD_W    = NUM_BANK * BANK_W;
    localparam int WIN_GAP  = 15 - NUM_W;

    typedef struct packed {
        logic                          wake_sel;
        logic [NUM_SRC-1:0]            slot_vld;
        logic [NUM_SRC-1:0][NUM_W-1:0] slot_num;
        logic                          win_vld;
        logic [NUM_W-1:0]              win_num;
        logic                          irq;
        logic                          fiq;
        logic                          wake;
        logic [DATA_W-1:0]             rdata;
    } top_state_t;

    top_state_t                     st_d, st_q;
    logic [PAD_W-1:0]               src_pad;
    logic [PAD_W-1:0]               enable_all;
    logic [PAD_W-1:0]               route_all;
    logic [PAD_W-1:0]               irq_all;
    logic [PAD_W-1:0]               fiq_all;
    logic [NUM_BANK-1:0][DATA_W-1:0] bank_rd;
    logic [MAX_SRC-1:0]             elig;
    logic                           found;
    logic [NUM_W-1:0]               win;
    logic                           win_vld_w;
    logic                           wake_sel_w;

    always_comb begin
        src_pad              = '0;
        src_pad[NUM_SRC-1:0] = src_i;
    end

    for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
        localparam int LEFT = NUM_SRC - BANK_W * b;
        localparam int LIVE = (LEFT > BANK_W) ? BANK_W : LEFT;
        bank_reg_e sel;
        assign sel = bank_decode(addr_i, bank_base(b));
        prio_intc_bank #(.LIVE(LIVE)) u_bank (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .wr_en_i   (wr_en_i),
            .sel_i     (sel),
            .wdata_i   (wdata_i),
            .src_i     (src_pad[BANK_W*b +: BANK_W]),
            .enable_o  (enable_all[BANK_W*b +: BANK_W]),
            .route_o   (route_all[BANK_W*b +: BANK_W]),
            .irq_vec_o (irq_all[BANK_W*b +: BANK_W]),
            .fiq_vec_o (fiq_all[BANK_W*b +: BANK_W]),
            .rd_o      (bank_rd[b])
        );
    end

    always_comb begin
        elig            = '0;
        elig[PAD_W-1:0] = irq_all;
    end

    prio_intc_sel #(.NUM_SLOT(NUM_SRC)) u_sel (
        .slot_vld_i (st_q.slot_vld),
        .slot_num_i (st_q.slot_num),
        .elig_i     (elig),
        .found_o    (found),
        .win_o      (win)
    );

    always_comb begin
        st_d = st_q;

        // register writes; pending and winner words take no writes
        if (wr_en_i && addr_i == CTRL_ADDR) st_d.wake_sel = wdata_i[0];
        for (int i = 0; i < NUM_SRC; i++) begin
            if (wr_en_i && addr_i == slot_addr(i)) begin
                st_d.slot_vld[i] = wdata_i[DATA_W-1];
                st_d.slot_num[i] = wdata_i[NUM_W-1:0];
            end
        end

        // registered outputs
        st_d.win_vld = found;
        st_d.win_num = win;
        st_d.irq     = |irq_all;
        st_d.fiq     = |fiq_all;
        st_d.wake    = st_q.wake_sel ? |(src_pad & enable_all) : |src_pad;

        // read mux
        st_d.rdata = '0;
        for (int b = 0; b < NUM_BANK; b++) st_d.rdata = st_d.rdata | bank_rd[b];
        if (addr_i == CTRL_ADDR) st_d.rdata = {{(DATA_W-1){1'b0}}, st_q.wake_sel};
        if (addr_i == WIN_ADDR)
            st_d.rdata = {st_q.win_vld, {WIN_GAP{1'b0}}, st_q.win_num, 16'h0000};
        for (int i = 0; i < NUM_SRC; i++) begin
            if (addr_i == slot_addr(i))
                st_d.rdata = {st_q.slot_vld[i], {(DATA_W-1-NUM_W){1'b0}}, st_q.slot_num[i]};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rdata_o    = st_q.rdata;
    assign irq_o      = st_q.irq;
    assign fiq_o      = st_q.fiq;
    assign wake_o     = st_q.wake;
    assign win_vld_w  = st_q.win_vld;
    assign wake_sel_w = st_q.wake_sel;

    logic unused_route;
    assign unused_route = |route_all;

endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk
    import prio_intc_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [NUM_SRC-1:0] src_i,
    input logic [ADDR_W-1:0]  addr_i,
    input logic [DATA_W-1:0]  rdata_o,
    input logic               irq_o,
    input logic               fiq_o,
    input logic               wake_o,
    input logic               win_vld,
    input logic               wake_sel
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk_i)
        !rst_ni |=> (!irq_o && !fiq_o && !wake_o && rdata_o == '0));

    // R5
    quiet_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(src_i) == '0) |-> (!irq_o && !fiq_o && !wake_o));

    // R6
    win_needs_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        win_vld |-> irq_o);

    // R8
    wake_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && !$past(wake_sel) && $past(src_i) != '0) |-> wake_o);

    // R9
    high_addr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(addr_i[ADDR_W-1])) |-> rdata_o == '0);

endmodule

bind prio_intc prio_intc_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_i    (src_i),
    .addr_i   (addr_i),
    .rdata_o  (rdata_o),
    .irq_o    (irq_o),
    .fiq_o    (fiq_o),
    .wake_o   (wake_o),
    .win_vld  (win_vld_w),
    .wake_sel (wake_sel_w)
);

// File: tb/sim_prio_intc.sv
module sim_prio_intc;

    localparam int N = 64;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  src;
    logic          wr_en;
    logic [11:0]   addr;
    logic [31:0]   wdata;
    logic [31:0]   rdata;
    logic          irq, fiq, wake;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    prio_intc #(.NUM_SRC(N)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .src_i(src), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .irq_o(irq), .fiq_o(fiq), .wake_o(wake)
    );

    typedef struct packed {
        logic [63:0] src;
        logic [63:0] en;
        logic [63:0] rt;
        logic        irq;
        logic        fiq;
        logic [31:0] win;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{64'h0, '1, 64'h0, 1'b0, 1'b0, 32'h0},
        '{64'h0000_0100_0000_0020, '1, 64'h0, 1'b1, 1'b0, 32'h8005_0000},
        '{64'h0000_0100_0000_0020, 64'h0000_0100_0000_0000, 64'h0, 1'b1, 1'b0, 32'h8028_0000},
        '{64'h0000_0100_0000_0000, '1, 64'h0000_0100_0000_0000, 1'b0, 1'b1, 32'h0},
        '{64'h8000_0000_0000_0008, '1, 64'h0000_0000_0000_0008, 1'b1, 1'b1, 32'h803F_0000},
        '{'1, 64'h0, 64'h0, 1'b0, 1'b0, 32'h0},
        '{'1, '1, ~64'h1, 1'b1, 1'b1, 32'h8000_0000}
    };

    function automatic logic [11:0] slot_a(input int i);
        return (i < 32) ? 12'(12'h01C + 4 * i) : 12'(12'h0B0 + 4 * (i - 32));
    endfunction

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        @(negedge clk);
        d = rdata;
    endtask

    task automatic set_src(input logic [N-1:0] s);
        @(negedge clk);
        src = s;
        @(negedge clk);
    endtask

    task automatic finish_up;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired got=running exp=done");
        finish_up();
    end

    initial begin
        logic [31:0] d;
        logic [31:0] prev;
        rst_n = 1'b0; src = '0; wr_en = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        chk("R1 outputs in reset", {irq, fiq, wake}, 3'b000);
        rst_n = 1'b1;
        rd(12'h004, d); chk("R1 enable0 after reset", d, 0);
        rd(12'h018, d); chk("R1 winner after reset", d, 0);
        rd(slot_a(3), d); chk("R1 slot3 after reset", d, 0);
        chk("R1 lines after reset", {irq, fiq, wake}, 3'b000);

        for (int i = 0; i < N; i++) wr(slot_a(i), 32'h8000_0000 | i);

        // table walk: R3 R5 R6
        for (int v = 0; v < 7; v++) begin
            wr(12'h004, VECS[v].en[31:0]);
            wr(12'h0A0, VECS[v].en[63:32]);
            wr(12'h008, VECS[v].rt[31:0]);
            wr(12'h0A4, VECS[v].rt[63:32]);
            set_src(VECS[v].src);
            chk($sformatf("R5 irq vec%0d", v), irq, VECS[v].irq);
            chk($sformatf("R5 fiq vec%0d", v), fiq, VECS[v].fiq);
            rd(12'h018, d); chk($sformatf("R6 winner vec%0d", v), d, VECS[v].win);
            rd(12'h000, d); chk($sformatf("R3 irq pend0 vec%0d", v), d,
                                (VECS[v].src & VECS[v].en & ~VECS[v].rt) & 64'hFFFF_FFFF);
            rd(12'h09C, d); chk($sformatf("R3 irq pend1 vec%0d", v), d,
                                (VECS[v].src & VECS[v].en & ~VECS[v].rt) >> 32);
            rd(12'h0A8, d); chk($sformatf("R3 fiq pend1 vec%0d", v), d,
                                (VECS[v].src & VECS[v].en & VECS[v].rt) >> 32);
        end

        // R5 latency: one clock from source to line
        wr(12'h008, 32'h0); wr(12'h0A4, 32'h0);
        set_src('0);
        @(negedge clk);
        src = 64'h80;
        #1 chk("R5 irq before edge", irq, 1'b0);
        @(negedge clk);
        chk("R5 irq after edge", irq, 1'b1);

        // R6 remapped priority
        wr(slot_a(0), 32'h8000_0032);
        wr(slot_a(1), 32'h8000_0002);
        set_src(64'h0004_0000_0000_0004);
        rd(12'h018, d); chk("R6 slot0 remapped wins", d, 32'h8032_0000);
        // R7 invalid slot ignored
        wr(slot_a(0), 32'h0000_0032);
        rd(12'h018, d); chk("R7 cleared slot skipped", d, 32'h8002_0000);
        rd(slot_a(0), d); chk("R7 slot readback", d, 32'h0000_0032);
        wr(slot_a(5), 32'hFFFF_FFFF);
        rd(slot_a(5), d); chk("R7 slot field width", d, 32'h8000_007F);
        set_src(64'h20);
        rd(12'h018, d); chk("R7 unslotted source no winner", d, 0);
        chk("R7 line still raised", irq, 1'b1);
        rd(slot_a(40), d); chk("R7 slot40 address", d, 32'h8000_0028);

        // R8 wakeup mode
        wr(12'h004, 32'h0); wr(12'h0A0, 32'h0);
        set_src(64'h200);
        chk("R8 open mode wake", wake, 1'b1);
        wr(12'h014, 32'hFFFF_FFFF);
        rd(12'h014, d); chk("R8 control readback", d, 32'h1);
        @(negedge clk);
        chk("R8 masked mode no wake", wake, 1'b0);
        wr(12'h004, 32'h200); wr(12'h008, 32'h200);
        @(negedge clk);
        chk("R8 masked mode enabled wake", wake, 1'b1);
        chk("R8 fast route", {irq, fiq}, 2'b01);

        // R2 raw word ignores enable and writes
        wr(12'h004, 32'h0);
        set_src(64'h1234_5678_9ABC_DEF0);
        rd(12'h010, d); chk("R2 raw bank0", d, 32'h9ABC_DEF0);
        wr(12'h0AC, 32'hFFFF_FFFF);
        rd(12'h0AC, d); chk("R2 raw bank1 after write", d, 32'h1234_5678);
        wr(12'h000, 32'hFFFF_FFFF);
        rd(12'h000, d); chk("R3 pend write ignored", d, 32'h0);

        // R4 bank1 registers
        wr(12'h0A0, 32'hA5A5_0F0F);
        rd(12'h0A0, d); chk("R4 enable1 readback", d, 32'hA5A5_0F0F);
        wr(12'h0A4, 32'h0F0F_A5A5);
        rd(12'h0A4, d); chk("R4 route1 readback", d, 32'h0F0F_A5A5);
        rd(12'h008, d); chk("R4 route0 readback", d, 32'h200);

        // R9 unmapped space
        wr(12'h800, 32'hFFFF_FFFF);
        rd(12'h800, d); chk("R9 high address reads zero", d, 0);
        rd(12'h144, d); chk("R9 absent slot64 reads zero", d, 0);
        rd(12'h0A0, d); chk("R9 write left enable1 alone", d, 32'hA5A5_0F0F);
        rd(12'h0B0, d); chk("R9 write left slot32 alone", d, 32'h8000_0020);

        // R10 read latency
        rd(12'h0A4, prev);
        @(negedge clk);
        addr = 12'h0A0;
        #1 chk("R10 data held before edge", rdata, prev);
        @(negedge clk);
        chk("R10 data after edge", rdata, 32'hA5A5_0F0F);

        finish_up();
    end

endmodule